// File: doc/BRIEF.md
# Debug Scan Chain Register

This block holds a row of debug storage bits that can be reached two ways. Serially, the bits form a scan path: a capture phase pulls each bit's serial input into its internal store, and a separate, non-overlapping launch phase copies the store onto that bit's serial output. That output feeds the next bit, and the last bit's output is the chain output. In parallel, every bit sits on its own data line. A read strobe loads each store with the inverse of its line. A write strobe makes each bit drive its line with the inverse of its store.

Both shift phases and both strobes are sampled as synchronous enables on a single system clock. The parallel side is split into an input bus, an output bus and an output-enable bus, so no tristate exists inside the block. Two strobe combinations are illegal: a read together with the capture phase, and a read together with a write. Either one sets a sticky error flag that only reset clears. The scan data is moved by phase strobes and has no flow control, so every pin stays a plain level signal with no valid/ready pairing. A host must sequence the phases itself.

Top module: `dbg_scan_chain`

## Requirements
- R1: After reset every store bit and every serial output register is 0. So `scan_out` is 0, `err` is 0, `par_oe` is all zeros and `par_out` is all ones.
- R2: On a clock edge where `ph_a` is 1 and `rd` is 0, store bit i takes the serial output of bit i-1. Store bit 0 takes `scan_in`.
- R3: On a clock edge where `ph_b` is 1, each bit's serial output register takes that bit's store value from before the edge. When `ph_b` is 0 the serial output registers hold their value.
- R4: On a clock edge where `rd` is 1, store bit i takes the inverse of `par_in[i]`. This applies even when `ph_a` is also 1.
- R5: `par_out[i]` always shows the inverse of store bit i in the same cycle. Every bit of `par_oe` equals `wr` in the same cycle.
- R6: A clock edge with `rd` and `ph_a` both 1 sets `err`. Once set, `err` stays 1 until reset.
- R7: A clock edge with `rd` and `wr` both 1 sets `err`. No other pairing of strobes and phases sets it, including `rd` with `ph_b` and `wr` with `ph_a`.
- R8: `scan_out` is the serial output register of bit N-1. After N capture/launch pairs, the first bit shifted in appears at `scan_out`.
- R9: On a clock edge where `ph_a` and `rd` are both 0, the store bits keep their value. `wr` alone changes no state.

Top module parameter: `N` (chain length, default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_a | input | 1 | Capture phase: serial input into store |
| ph_b | input | 1 | Launch phase: store onto serial output |
| scan_in | input | 1 | Serial input to bit 0 |
| rd | input | 1 | Parallel read strobe (store takes inverted line) |
| wr | input | 1 | Parallel write strobe (drive inverted store) |
| par_in | input | N | Parallel data lines as seen by the block |
| par_out | output | N | Inverted store values for the lines |
| par_oe | output | N | Line drive enables, all equal to `wr` |
| scan_out | output | 1 | Serial output of the last bit |
| err | output | 1 | Sticky illegal-strobe flag |

## Verification
Store updates, serial output updates and the error flag all land on the first clock edge after the inputs that cause them. The bench drives inputs at the falling edge and samples one falling edge later, so exactly one rising edge falls in between. `par_out` and `par_oe` are combinational, so write-strobe checks sample one time unit after the falling-edge drive, before any rising edge. A serial value takes one capture/launch pair per stage. The full-chain check therefore counts N pairs before it reads `scan_out`.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // Per-bit control, shared by every cell of the chain
  typedef struct packed {
    logic cap;    // capture phase
    logic launch; // launch phase
    logic load;   // parallel read
  } dsc_ctl_t;

endpackage

// File: rtl/dsc_cell.sv
module dsc_cell
  import dsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dsc_ctl_t ctl,
  input  logic     ser_in,
  input  logic     line_in,
  output logic     store_q,
  output logic     ser_q
);

  logic store_d;

  // Parallel read wins over capture (R4)
  always_comb begin
    store_d = store_q;
    if (ctl.load)      store_d = ~line_in;
    else if (ctl.cap)  store_d = ser_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      ser_q   <= 1'b0;
    end else begin
      store_q <= store_d;
      if (ctl.launch) ser_q <= store_q;
    end
  end

  AST_LOAD_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> store_q == ~$past(line_in)); // R4
  AST_CAP_TAKES_SER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cap && !ctl.load) |=> store_q == $past(ser_in)); // R2
  AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cap && !ctl.load) |=> $stable(store_q)); // R9
  AST_LAUNCH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.launch |=> ser_q == $past(store_q)); // R3
  AST_SER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.launch |=> $stable(ser_q)); // R3

endmodule

// File: rtl/dsc_err_guard.sv
module dsc_err_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic load,
  input  logic drive,
  output logic err_q
);

  logic bad_rd_cap;
  logic bad_rd_wr;

  assign bad_rd_cap = load & cap;
  assign bad_rd_wr  = load & drive;

  always_ff @(posedge clk) begin
    if (!rst_n)                       err_q <= 1'b0;
    else if (bad_rd_cap || bad_rd_wr) err_q <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R6
  AST_ERR_RD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cap) |=> err_q); // R6
  AST_ERR_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (load && drive) |=> err_q); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && !load) |=> !err_q); // R7

endmodule

// File: rtl/dsc_line_drv.sv
module dsc_line_drv #(
  parameter int N = 8
) (
  input  logic         drive,
  input  logic [N-1:0] store,
  output logic [N-1:0] line_out,
  output logic [N-1:0] line_oe
);

  assign line_out = ~store;
  assign line_oe  = {N{drive}};

endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
  import dsc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph_a,
  input  logic         ph_b,
  input  logic         scan_in,
  input  logic         rd,
  input  logic         wr,
  input  logic [N-1:0] par_in,
  output logic [N-1:0] par_out,
  output logic [N-1:0] par_oe,
  output logic         scan_out,
  output logic         err
);

  localparam int LAST = N - 1;

  dsc_ctl_t     ctl;
  logic [N:0]   link;
  logic [N-1:0] store;

  assign ctl.cap    = ph_a;
  assign ctl.launch = ph_b;
  assign ctl.load   = rd;
  assign link[0]    = scan_in;

  for (genvar i = 0; i < N; i++) begin : g_bit
    dsc_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl),
      .ser_in  (link[i]),
      .line_in (par_in[i]),
      .store_q (store[i]),
      .ser_q   (link[i+1])
    );
  end

  assign scan_out = link[LAST+1];

  dsc_line_drv #(.N(N)) u_drv (
    .drive    (wr),
    .store    (store),
    .line_out (par_out),
    .line_oe  (par_oe)
  );

  dsc_err_guard u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (ph_a),
    .load  (rd),
    .drive (wr),
    .err_q (err)
  );

  AST_OE_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (&par_oe)); // R5
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> (par_oe == '0)); // R5
  AST_WR_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && !ph_a) |=> $stable(par_out)); // R9

endmodule

// File: tb/dbg_scan_chain_tb_top.sv
module dbg_scan_chain_tb_top;

  localparam int N = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n, ph_a, ph_b, scan_in, rd, wr;
  logic [N-1:0] par_in, par_out, par_oe;
  logic scan_out, err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  dbg_scan_chain #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .scan_in(scan_in),
    .rd(rd), .wr(wr), .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .scan_out(scan_out), .err(err)
  );

  // {ph_a, ph_b, rd, wr, scan_in, par_in[7:0], exp_par_out[7:0], exp_scan_out}
  localparam logic [21:0] VEC [NV] = '{
    {5'b00100, 8'h5A, 8'h5A, 1'b0},  // R4 read: store A5
    {5'b01000, 8'h00, 8'h5A, 1'b1},  // R3 launch: ser A5
    {5'b10000, 8'h00, 8'hB5, 1'b1},  // R2 capture si=0: store 4A
    {5'b01000, 8'h00, 8'hB5, 1'b0},  // R3 launch: ser 4A
    {5'b10001, 8'h00, 8'h6A, 1'b0},  // R2 capture si=1: store 95
    {5'b00000, 8'hC3, 8'h6A, 1'b0},  // R9 idle hold
    {5'b01000, 8'h00, 8'h6A, 1'b1},  // R3 launch: ser 95
    {5'b00100, 8'hFF, 8'hFF, 1'b1},  // R4 read: store 00
    {5'b10001, 8'h00, 8'hD4, 1'b1},  // R2 capture si=1: store 2B
    {5'b01000, 8'h00, 8'hD4, 1'b0}   // R8 launch: ser 2B
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic r, input logic w,
                       input logic si, input logic [N-1:0] pin);
    ph_a = a; ph_b = b; rd = r; wr = w; scan_in = si; par_in = pin;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    drive(0, 0, 0, 0, 0, '0);
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(par_out == 8'hFF, "R1 par_out", par_out, 8'hFF);
    chk(par_oe == 8'h00, "R1 par_oe", par_oe, 8'h00);
    chk(scan_out == 1'b0, "R1 scan_out", scan_out, 0);
    chk(err == 1'b0, "R1 err", err, 0);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16:9]);
      step();
      chk(par_out == VEC[v][8:1], "R2/R3/R4 table par_out", par_out, VEC[v][8:1]);
      chk(scan_out == VEC[v][0], "R3/R8 table scan_out", scan_out, VEC[v][0]);
      chk(err == 1'b0, "R7 table err", err, 0);
    end

    // R5 write strobe: combinational drive of inverted store (store = 2B)
    drive(0, 0, 0, 1, 0, '0);
    #1;
    chk(par_oe == 8'hFF, "R5 oe with wr", par_oe, 8'hFF);
    chk(par_out == 8'hD4, "R5 out with wr", par_out, 8'hD4);
    step();
    chk(par_out == 8'hD4, "R9 wr alone keeps store", par_out, 8'hD4);
    drive(0, 0, 0, 0, 0, '0);
    #1;
    chk(par_oe == 8'h00, "R5 oe without wr", par_oe, 8'h00);

    // R7 negative: wr with ph_a and rd with ph_b leave err clear
    @(negedge clk);
    drive(1, 0, 0, 1, 0, '0);
    step();
    drive(0, 1, 1, 0, 0, 8'h0F);
    step();
    chk(err == 1'b0, "R7 legal pairs no err", err, 0);

    // R8 full chain shift of pattern, first bit in = pat[7]
    do_reset();
    pat = 8'b1011_0010;
    for (int k = N - 1; k >= 0; k--) begin
      drive(1, 0, 0, 0, pat[k], '0);
      step();
      drive(0, 1, 0, 0, 0, '0);
      step();
    end
    chk(par_out == ~pat, "R8 chain store", par_out, ~pat);
    chk(scan_out == pat[7], "R8 chain scan_out", scan_out, pat[7]);

    // R4 + R6: read with capture, read wins, err sticky
    drive(1, 0, 1, 0, 1, 8'h0F);
    step();
    chk(par_out == 8'h0F, "R4 read over capture", par_out, 8'h0F);
    chk(err == 1'b1, "R6 rd+ph_a err", err, 1);
    drive(0, 0, 0, 0, 0, '0);
    step(); step();
    chk(err == 1'b1, "R6 err sticky", err, 1);
    do_reset();
    chk(err == 1'b0, "R6 err cleared by reset", err, 0);

    // R7: read with write sets err, store still takes inverted line
    drive(0, 0, 1, 1, 0, 8'h3C);
    step();
    chk(err == 1'b1, "R7 rd+wr err", err, 1);
    chk(par_out == 8'h3C, "R7 store on rd+wr", par_out, 8'h3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule